// File: doc/BRIEF.md
# Serial Tag Frame Decoder

This block sits behind a byte-wide serial receiver and turns the ASCII-hex text that a 125 kHz proximity tag reader sends into a 32-bit binary tag ID. Each received byte arrives with a one-cycle load strobe. The decoder follows the fixed frame layout with a state machine and a per-field character counter, and converts pairs of hex characters into bytes. As each ID byte completes, the decoder writes it into an external four-entry byte register bank through a data/strobe/select write port.

A frame is 16 bytes long. The sequence is fixed and is part of the behaviour: start byte 0x02, ten hex data characters, two hex checksum characters, 0x0D, 0x0A, and end byte 0x03. The ten data characters give five bytes. The first byte is a header and is dropped. The other four bytes form the ID. The decoder XORs all five bytes together and compares the result with the transmitted checksum byte. Two sticky flags report errors: one for a layout error and one for a checksum mismatch. The state and the counter are brought out for debugging.

Top module: `rfp_top`

## Requirements
- R1: In the cycle after synchronous reset, the write strobe, write data, select, both error flags, debug state and debug counter are all zero.
- R2: A byte is consumed only in a cycle where load_i is high. While the state is idle (debug state 0), any loaded byte other than 0x02 changes nothing and causes no write.
- R3: Hex characters '0'-'9', 'A'-'F' and 'a'-'f' are accepted. Each pair of characters becomes one byte, and the first character of the pair is the upper nibble.
- R4: Of the five decoded data bytes, the first is never written. Bytes two to five are written in that order with select values 3, 2, 1, 0. Each write is a one-cycle wr_en_o pulse, with data and select valid in the same cycle. The pulse comes in the cycle after the load of the second character of that byte.
- R5: When the second checksum character is loaded, sum_err_o goes high if the decoded checksum byte differs from the XOR of the five data bytes. The state then returns to idle.
- R6: A character in a data or checksum position that is not a hex digit sets fmt_err_o and returns the state to idle.
- R7: After the checksum, the next three bytes must be 0x0D, 0x0A and 0x03. Any other byte in one of these positions sets fmt_err_o and returns the state to idle.
- R8: A loaded 0x02, in any state, clears both error flags and moves to the first data character: debug state 1, counter 0.
- R9: The debug state encodes idle=0, data=1, checksum=2, CR=3, LF=4, end=5. The debug counter holds the number of characters already accepted in the current data or checksum field, and is 0 in the other states.
- R10: A complete, correct frame leaves both flags low and the state idle once its 0x03 end byte is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | One-cycle strobe marking a valid received byte |
| din_i | input | 8 | Received byte |
| wr_en_o | output | 1 | Register bank write strobe |
| wr_data_o | output | 8 | Byte to write |
| wr_sel_o | output | 2 | Register bank entry select |
| fmt_err_o | output | 1 | Frame layout error flag |
| sum_err_o | output | 1 | Checksum mismatch flag |
| dbg_state_o | output | 3 | Current state for debugging |
| dbg_count_o | output | 4 | Character counter for debugging |

## Verification
A table of whole frames exercises the main path. The frames differ in header and ID values, use upper- or lowercase hex, and carry a correct or a deliberately wrong checksum. This separates a correct nibble order and case handling from swapped or case-blind decoding, and tells a header write or a wrong select order apart from the intended 3-2-1-0 sequence. Further frames corrupt a single position: a data character, a checksum character, or one of the three trailing delimiters. These show that each field position is checked by itself. Directed runs then cover noise bytes while idle, a restart on 0x02 in the middle of a frame, counter values partway through a field, and the single-cycle width of the write pulse.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DATA = 3'd1,
    ST_SUM  = 3'd2,
    ST_CR   = 3'd3,
    ST_LF   = 3'd4,
    ST_END  = 3'd5
  } rfp_state_e;
endpackage

// File: rtl/rfp_hexdec.sv
module rfp_hexdec
  import rfp_pkg::*;
(
  input  logic [BYTE_W-1:0] char_i,
  output logic              ok_o,
  output logic [NIB_W-1:0]  nib_o
);
  logic [BYTE_W-1:0] diff;

  always_comb begin
    ok_o  = 1'b0;
    diff  = '0;
    if (char_i >= 8'h30 && char_i <= 8'h39) begin
      ok_o = 1'b1;
      diff = char_i - 8'h30;
    end else if (char_i >= 8'h41 && char_i <= 8'h46) begin
      ok_o = 1'b1;
      diff = char_i - 8'h37;
    end else if (char_i >= 8'h61 && char_i <= 8'h66) begin
      ok_o = 1'b1;
      diff = char_i - 8'h57;
    end
    nib_o = diff[NIB_W-1:0];
  end
endmodule

// File: rtl/rfp_xorsum.sv
module rfp_xorsum
  import rfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] sum_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) sum_o <= '0;
    else if (add_i)   sum_o <= sum_o ^ byte_i;
  end
endmodule

// File: rtl/rfp_top.sv
module rfp_top
  import rfp_pkg::*;
#(
  parameter int          ID_BYTES  = 4,
  parameter int          HDR_BYTES = 1,
  parameter logic [7:0]  CH_START  = 8'h02,
  parameter logic [7:0]  CH_END    = 8'h03,
  parameter logic [7:0]  CH_CR     = 8'h0D,
  parameter logic [7:0]  CH_LF     = 8'h0A,
  parameter int          SEL_W     = $clog2(ID_BYTES),
  parameter int          CNT_W     = $clog2(2 * (ID_BYTES + HDR_BYTES) + 1)
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [BYTE_W-1:0]   din_i,
  output logic                wr_en_o,
  output logic [BYTE_W-1:0]   wr_data_o,
  output logic [SEL_W-1:0]    wr_sel_o,
  output logic                fmt_err_o,
  output logic                sum_err_o,
  output logic [2:0]          dbg_state_o,
  output logic [CNT_W-1:0]    dbg_count_o
);
  localparam int DATA_CHARS = 2 * (ID_BYTES + HDR_BYTES);
  localparam int LAST_IDX   = ID_BYTES + HDR_BYTES - 1;
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_CHARS - 1);
  localparam logic [CNT_W-1:0] HDR_C     = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_C    = CNT_W'(LAST_IDX);

  rfp_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NIB_W-1:0]  hi_q;
  logic              nib_ok;
  logic [NIB_W-1:0]  nib;
  logic [BYTE_W-1:0] pair;
  logic [BYTE_W-1:0] csum;
  logic [CNT_W-1:0]  byte_idx;
  logic [CNT_W-1:0]  sel_full;
  logic              is_start;
  logic              sum_add;

  rfp_hexdec u_hex (
    .char_i (din_i),
    .ok_o   (nib_ok),
    .nib_o  (nib)
  );

  assign pair     = {hi_q, nib};
  assign byte_idx = {1'b0, cnt_q[CNT_W-1:1]};
  assign sel_full = LAST_C - byte_idx;
  assign is_start = load_i && (din_i == CH_START);
  assign sum_add  = load_i && !is_start && (state_q == ST_DATA) && nib_ok && cnt_q[0];

  rfp_xorsum u_sum (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (is_start),
    .add_i  (sum_add),
    .byte_i (pair),
    .sum_o  (csum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      hi_q      <= '0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
      wr_sel_o  <= '0;
      fmt_err_o <= 1'b0;
      sum_err_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (is_start) begin
        state_q   <= ST_DATA;
        cnt_q     <= '0;
        fmt_err_o <= 1'b0;
        sum_err_o <= 1'b0;
      end else if (load_i) begin
        case (state_q)
          ST_IDLE: ;
          ST_DATA: begin
            if (!nib_ok) begin
              fmt_err_o <= 1'b1;
              state_q   <= ST_IDLE;
              cnt_q     <= '0;
            end else begin
              if (!cnt_q[0]) hi_q <= nib;
              else if (byte_idx >= HDR_C) begin
                wr_en_o   <= 1'b1;
                wr_data_o <= pair;
                wr_sel_o  <= sel_full[SEL_W-1:0];
              end
              if (cnt_q == LAST_DATA) begin
                state_q <= ST_SUM;
                cnt_q   <= '0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_SUM: begin
            if (!nib_ok) begin
              fmt_err_o <= 1'b1;
              state_q   <= ST_IDLE;
              cnt_q     <= '0;
            end else if (!cnt_q[0]) begin
              hi_q  <= nib;
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q     <= '0;
              sum_err_o <= (pair != csum);
              state_q   <= (pair != csum) ? ST_IDLE : ST_CR;
            end
          end
          ST_CR: begin
            state_q <= (din_i == CH_CR) ? ST_LF : ST_IDLE;
            if (din_i != CH_CR) fmt_err_o <= 1'b1;
          end
          ST_LF: begin
            state_q <= (din_i == CH_LF) ? ST_END : ST_IDLE;
            if (din_i != CH_LF) fmt_err_o <= 1'b1;
          end
          ST_END: begin
            state_q <= ST_IDLE;
            if (din_i != CH_END) fmt_err_o <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign dbg_state_o = state_q;
  assign dbg_count_o = cnt_q;
endmodule

// File: rtl/rfp_checker.sv
module rfp_checker #(
  parameter int CNT_W = 4,
  parameter int SEL_W = 2
)(
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic [7:0]       din_i,
  input logic             wr_en_o,
  input logic [SEL_W-1:0] wr_sel_o,
  input logic             fmt_err_o,
  input logic             sum_err_o,
  input logic [2:0]       dbg_state_o,
  input logic [CNT_W-1:0] dbg_count_o
);
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o); // R4
  AST_WR_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(load_i)); // R4
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (dbg_state_o == 3'd0) |-> !wr_en_o); // R2
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(dbg_state_o) && $stable(dbg_count_o) && $stable(fmt_err_o) && $stable(sum_err_o))); // R2
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (load_i && din_i == 8'h02) |=> (dbg_state_o == 3'd1 && dbg_count_o == '0 && !fmt_err_o && !sum_err_o)); // R8
  AST_SUM_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(sum_err_o) |-> (dbg_state_o == 3'd0)); // R5
  AST_FMT_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(fmt_err_o) |-> (dbg_state_o == 3'd0)); // R6
  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
    dbg_state_o <= 3'd5); // R9
endmodule

bind rfp_top rfp_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .load_i      (load_i),
  .din_i       (din_i),
  .wr_en_o     (wr_en_o),
  .wr_sel_o    (wr_sel_o),
  .fmt_err_o   (fmt_err_o),
  .sum_err_o   (sum_err_o),
  .dbg_state_o (dbg_state_o),
  .dbg_count_o (dbg_count_o)
);

// File: tb/test_rfp_top.sv
`timescale 1ns/1ps
module test_rfp_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_i = 1'b0;
  logic [7:0] din_i = 8'h00;
  logic       wr_en_o;
  logic [7:0] wr_data_o;
  logic [1:0] wr_sel_o;
  logic       fmt_err_o, sum_err_o;
  logic [2:0] dbg_state_o;
  logic [3:0] dbg_count_o;

  int checks = 0;
  int fails  = 0;
  int nwr    = 0;
  int dbl    = 0;
  logic [7:0] bank [4];
  logic [7:0] sel_hist = '0;
  logic       prev_wr = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  rfp_top i_rfp_top (
    .clk(clk), .rst(rst), .load_i(load_i), .din_i(din_i),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .wr_sel_o(wr_sel_o),
    .fmt_err_o(fmt_err_o), .sum_err_o(sum_err_o),
    .dbg_state_o(dbg_state_o), .dbg_count_o(dbg_count_o)
  );

  always @(negedge clk) begin
    if (!rst && wr_en_o) begin
      bank[wr_sel_o] = wr_data_o;
      nwr++;
      sel_hist = {sel_hist[5:0], wr_sel_o};
      if (prev_wr) dbl++;
    end
    prev_wr = wr_en_o;
  end

  // fields: [41:34] header, [33:2] id, [1] lowercase, [0] wrong checksum
  localparam logic [41:0] VECS [0:5] = '{
    {8'h12, 32'hDEADBEEF, 1'b0, 1'b0},
    {8'h00, 32'h00000000, 1'b0, 1'b0},
    {8'hFF, 32'hFFFFFFFF, 1'b1, 1'b0},
    {8'hA5, 32'h01234567, 1'b1, 1'b0},
    {8'h3C, 32'h89ABCDEF, 1'b0, 1'b1},
    {8'h7E, 32'hC0FFEE42, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    return (lower ? 8'h57 : 8'h37) + {4'h0, n};
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    din_i  = b;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // cpos: position 0..15 to replace with cval (99 = none); from: first position sent
  task automatic send_frame(input logic [7:0] hdr, input logic [31:0] id, input bit lower,
                            input bit badsum, input int cpos, input logic [7:0] cval,
                            input int from);
    logic [7:0] fr [16];
    logic [7:0] by [5];
    logic [7:0] s;
    by[0] = hdr; by[1] = id[31:24]; by[2] = id[23:16]; by[3] = id[15:8]; by[4] = id[7:0];
    s = '0;
    for (int i = 0; i < 5; i++) s ^= by[i];
    if (badsum) s ^= 8'h01;
    fr[0] = 8'h02;
    for (int i = 0; i < 5; i++) begin
      fr[1 + 2*i] = hexc(by[i][7:4], lower);
      fr[2 + 2*i] = hexc(by[i][3:0], lower);
    end
    fr[11] = hexc(s[7:4], lower);
    fr[12] = hexc(s[3:0], lower);
    fr[13] = 8'h0D; fr[14] = 8'h0A; fr[15] = 8'h03;
    if (cpos >= 0 && cpos < 16) fr[cpos] = cval;
    for (int i = from; i < 16; i++) send(fr[i]);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({wr_en_o, wr_data_o, wr_sel_o, fmt_err_o, sum_err_o, dbg_state_o, dbg_count_o} == '0,
        "R1", "reset outputs", {14'h0, wr_en_o, wr_data_o, wr_sel_o, fmt_err_o, sum_err_o},
        32'h0);

    // table walk: whole frames
    for (int v = 0; v < 6; v++) begin
      w0 = nwr;
      for (int k = 0; k < 4; k++) bank[k] = 8'hXX;
      send_frame(VECS[v][41:34], VECS[v][33:2], VECS[v][1], VECS[v][0], 99, 8'h00, 0);
      @(negedge clk);
      chk({bank[3], bank[2], bank[1], bank[0]} === VECS[v][33:2], "R3", "decoded id",
          {bank[3], bank[2], bank[1], bank[0]}, VECS[v][33:2]);
      chk(nwr - w0 == 4, "R4", "writes per frame (header skipped)", nwr - w0, 4);
      chk(sel_hist == 8'hE4, "R4", "select order 3,2,1,0", {24'h0, sel_hist}, 32'hE4);
      chk(sum_err_o == VECS[v][0], "R5", "checksum flag", {31'h0, sum_err_o}, {31'h0, VECS[v][0]});
      chk(fmt_err_o == 1'b0 && dbg_state_o == 3'd0, "R10", "flags and idle after frame",
          {28'h0, fmt_err_o, dbg_state_o}, 32'h0);
    end

    // R2: idle noise and bytes without load
    w0 = nwr;
    send(8'h41); send(8'h30); send(8'h0D); send(8'h03);
    din_i = 8'h02;
    repeat (4) @(negedge clk);
    chk(dbg_state_o == 3'd0 && dbg_count_o == 4'd0 && nwr == w0, "R2", "idle ignores noise",
        {dbg_state_o, dbg_count_o}, 32'h0);

    // R9 / R4: partial frame, counter and write pulse
    send(8'h02); send(8'h31); send(8'h61); send(8'h33);
    chk(dbg_state_o == 3'd1 && dbg_count_o == 4'd3, "R9", "state/count after 3 chars",
        {dbg_state_o, dbg_count_o}, {3'd1, 4'd3});
    send(8'h34);
    chk(wr_en_o && wr_sel_o == 2'd3 && wr_data_o == 8'h34, "R4", "first id write",
        {wr_en_o, wr_sel_o, wr_data_o}, {1'b1, 2'd3, 8'h34});
    @(negedge clk);
    chk(!wr_en_o, "R4", "write is one cycle", {31'h0, wr_en_o}, 32'h0);

    // R6: bad data char
    send(8'h47);
    chk(fmt_err_o && dbg_state_o == 3'd0, "R6", "non-hex data char",
        {fmt_err_o, dbg_state_o}, {1'b1, 3'd0});
    // R8: start clears flags
    send(8'h02);
    chk(!fmt_err_o && dbg_state_o == 3'd1 && dbg_count_o == 4'd0, "R8", "start clears flag",
        {fmt_err_o, dbg_state_o, dbg_count_o}, {1'b0, 3'd1, 4'd0});
    // R8: restart mid-frame then complete frame
    send(8'h39); send(8'h38); send(8'h37);
    send_frame(8'h55, 32'h13579BDF, 1'b0, 1'b0, 99, 8'h00, 0);
    @(negedge clk);
    chk({bank[3], bank[2], bank[1], bank[0]} === 32'h13579BDF && !fmt_err_o && !sum_err_o, "R8",
        "restart mid-frame", {bank[3], bank[2], bank[1], bank[0]}, 32'h13579BDF);

    // R6: non-hex checksum char
    send_frame(8'h11, 32'h22334455, 1'b0, 1'b0, 11, 8'h7A, 0);
    chk(fmt_err_o && !sum_err_o && dbg_state_o == 3'd0, "R6", "non-hex checksum char",
        {fmt_err_o, sum_err_o, dbg_state_o}, {1'b1, 1'b0, 3'd0});
    // R7: wrong CR, LF, end
    send_frame(8'h11, 32'h22334455, 1'b0, 1'b0, 13, 8'h0E, 0);
    chk(fmt_err_o && dbg_state_o == 3'd0, "R7", "bad CR", {fmt_err_o, dbg_state_o}, {1'b1, 3'd0});
    send_frame(8'h11, 32'h22334455, 1'b0, 1'b0, 14, 8'h0D, 0);
    chk(fmt_err_o && dbg_state_o == 3'd0, "R7", "bad LF", {fmt_err_o, dbg_state_o}, {1'b1, 3'd0});
    send_frame(8'h11, 32'h22334455, 1'b0, 1'b0, 15, 8'h04, 0);
    chk(fmt_err_o && dbg_state_o == 3'd0, "R7", "bad end byte", {fmt_err_o, dbg_state_o}, {1'b1, 3'd0});
    // R9: checksum state counter
    send_frame(8'h11, 32'h22334455, 1'b0, 1'b0, 12, 8'h0D, 0);
    send(8'h02);
    for (int i = 0; i < 11; i++) send(8'h30);
    chk(dbg_state_o == 3'd2 && dbg_count_o == 4'd1, "R9", "checksum field count",
        {dbg_state_o, dbg_count_o}, {3'd2, 4'd1});
    chk(dbl == 0, "R4", "no back-to-back writes", dbl, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule